// File: doc/BRIEF.md
# Interrupt flag and mask unit

This peripheral gathers four interrupt sources into a four-bit flag register and combines them with a four-bit enable mask. The result is a single interrupt request to the processor. Two sources are external pins, an interrupt line and a port line, and their flags are set on rising edges. The other two are events from a serial shifter: receive complete and transmit complete. Each flag has its own clearing rule. The processor writes the two pin flags directly. The receive flag clears when the received data is read, and it is held clear while a byte is being shifted in. The transmit flag clears when new transmit data is loaded.

The processor reaches the unit over a narrow register-select bus with a 4-bit select, separate read and write enables, and 8-bit data. Read data is registered and appears one cycle after the read enable. The mask register is read together with the synchronized live levels of four status lines. The shifter and the port data paths sit outside this block. They are seen only as event strobes and status levels.

Top module: `intflag_unit`

## Requirements
- R1: After a synchronous reset all flags, all mask bits, `int_req` and `rdata` are 0.
- R2: Select 4'b1010 addresses the mask. A write with `wr_en` loads `wdata[3:0]` into the mask. A read with `rd_en` returns the mask in `rdata[3:0]` one cycle later.
- R3: A mask read returns four synchronized live levels in the upper nibble: bit 4 is the interrupt pin, bit 5 is the port pin, bit 6 is the serial data status line and bit 7 is the clock status line. Each level passes through two flops.
- R4: Flag bit 0 is set on a rising edge of the interrupt pin and flag bit 1 on a rising edge of the port pin. The flag is visible in the register three cycles after the pin rises.
- R5: Select 4'b1011 addresses the flags. A read returns the flags in `rdata[3:0]` with bits 7:4 at 0. A write updates only bits 0 and 1 from `wdata[1:0]`; bits 2 and 3 are unaffected.
- R6: Flag bit 2 is set by `rx_done`. It is cleared by the `rx_data_rd` strobe, and it is held cleared in every cycle that `rx_busy` is high.
- R7: Flag bit 3 is set by `tx_done` and cleared by the `tx_load` strobe.
- R8: When a set event and any clearing cause (a write, a strobe or `rx_busy`) fall in the same cycle, the flag ends up set.
- R9: `int_req` is registered. It equals the OR of (flags AND mask), taken one cycle earlier.
- R10: Reads have no side effects. When `rd_en` is low, or the select matches neither register, `rdata` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 4 | Register select |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_pin | input | 1 | External interrupt pin (asynchronous) |
| pb_pin | input | 1 | Port pin used as interrupt source (asynchronous) |
| cl_stat | input | 1 | Serial clock status line (asynchronous) |
| sd_stat | input | 1 | Serial data status line (asynchronous) |
| rx_done | input | 1 | Receive-complete event strobe |
| rx_busy | input | 1 | Reception of data bits in progress |
| rx_data_rd | input | 1 | Received-data-register read strobe |
| tx_done | input | 1 | Transmit-complete event strobe |
| tx_load | input | 1 | Transmit-register load strobe |
| int_req | output | 1 | Combined registered interrupt request |

## Verification
The collision that matters is a flag's set event arriving in the same cycle as one of its clearing causes. For the pin flags that cause is a processor write of 0, and for the serial flags it is a data-register strobe or the busy level. Directed steps drive `rx_done` together with `rx_data_rd` and `rx_busy`, and `tx_done` together with `tx_load`, then read the flag register back and expect the bits set. A long random phase lets pin edges land on flag writes at arbitrary alignments. Every cycle, `rdata` and `int_req` are compared against a behavioural model in which set always wins.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  localparam int SEL_W   = 4;
  localparam int DATA_W  = 8;
  localparam int NSRC    = 4;
  localparam logic [SEL_W-1:0] SEL_MASK = 4'b1010;
  localparam logic [SEL_W-1:0] SEL_FLAG = 4'b1011;
  // flag/mask bit positions
  localparam int B_IRQ = 0;
  localparam int B_PB  = 1;
  localparam int B_RX  = 2;
  localparam int B_TX  = 3;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= din;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~prev;

  // R4: an edge pulse lasts a single cycle
  p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] wen_i,
  input  logic [N-1:0] wval_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
      else if (wen_i[i])  flag_o[i] <= wval_i[i];
    end
  end

  // R8: a set event always leaves the flag set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));
  // R6 R7: a clear without a set leaves the flag low
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/intflag_unit.sv
module intflag_unit
  import intflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              irq_pin,
  input  logic              pb_pin,
  input  logic              cl_stat,
  input  logic              sd_stat,
  input  logic              rx_done,
  input  logic              rx_busy,
  input  logic              rx_data_rd,
  input  logic              tx_done,
  input  logic              tx_load,
  output logic              int_req
);
  localparam int PAD_W = DATA_W - NSRC;

  logic [3:0]      lvl, rise;
  logic [NSRC-1:0] flags, mask, set_v, clr_v, wen_v;
  logic            wr_flag, wr_mask;

  // order: irq, pb, sd, cl -> levels land on rdata[7:4] in this order
  edge_sync #(.W(4)) u_sync (
    .clk (clk), .rst (rst),
    .din ({cl_stat, sd_stat, pb_pin, irq_pin}),
    .lvl (lvl), .rise (rise)
  );

  assign wr_flag = wr_en && (sel == SEL_FLAG);
  assign wr_mask = wr_en && (sel == SEL_MASK);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    wen_v = '0;
    set_v[B_IRQ] = rise[0];
    set_v[B_PB]  = rise[1];
    set_v[B_RX]  = rx_done;
    set_v[B_TX]  = tx_done;
    clr_v[B_RX]  = rx_data_rd | rx_busy;
    clr_v[B_TX]  = tx_load;
    wen_v[B_IRQ] = wr_flag;
    wen_v[B_PB]  = wr_flag;
  end

  flag_bank #(.N(NSRC)) u_flags (
    .clk (clk), .rst (rst),
    .set_i (set_v), .clr_i (clr_v), .wen_i (wen_v),
    .wval_i (wdata[NSRC-1:0]), .flag_o (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '0;
      rdata   <= '0;
      int_req <= 1'b0;
    end else begin
      if (wr_mask) mask <= wdata[NSRC-1:0];
      int_req <= |(flags & mask);
      if (rd_en && sel == SEL_MASK)      rdata <= {lvl, mask};
      else if (rd_en && sel == SEL_FLAG) rdata <= {{PAD_W{1'b0}}, flags};
      else                               rdata <= '0;
    end
  end

  // R9: enabled pending flag raises the request next cycle
  p_int_follow_r9: assert property (@(posedge clk) disable iff (rst)
    ((flags & mask) != '0) |=> int_req);
  p_int_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((flags & mask) == '0) |=> !int_req);
  // R6: busy without completion keeps the receive flag low
  p_busy_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_busy && !rx_done) |=> !flags[B_RX]);
  // R5: flag register upper nibble reads 0
  p_flag_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_FLAG) |=> (rdata[DATA_W-1:NSRC] == '0));
  // R10: no read, no data
  p_idle_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> (rdata == '0));
endmodule

// File: tb/intflag_unit_test.sv
module intflag_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [3:0] sel = 0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_pin = 0, pb_pin = 0, cl_stat = 0, sd_stat = 0;
  logic rx_done = 0, rx_busy = 0, rx_data_rd = 0, tx_done = 0, tx_load = 0;
  logic int_req;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intflag_unit uut (
    .clk(clk), .rst(rst), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq_pin(irq_pin), .pb_pin(pb_pin),
    .cl_stat(cl_stat), .sd_stat(sd_stat), .rx_done(rx_done),
    .rx_busy(rx_busy), .rx_data_rd(rx_data_rd), .tx_done(tx_done),
    .tx_load(tx_load), .int_req(int_req)
  );

  // behavioural reference: pin histories, flags, mask
  bit [3:0] pin_h1, pin_h2, pin_h3; // {cl,sd,pb,irq} delayed 1,2,3 cycles
  bit [3:0] m_flag, m_mask;
  bit [7:0] m_rdata;
  bit       m_int;
  string    rd_tag = "R10";

  always @(posedge clk) begin
    bit [3:0] nf;
    if (rst) begin
      pin_h1 = 0; pin_h2 = 0; pin_h3 = 0;
      m_flag = 0; m_mask = 0; m_rdata = 0; m_int = 0;
    end else begin
      nf = m_flag;
      if (wr_en && sel == 4'b1011) begin nf[0] = wdata[0]; nf[1] = wdata[1]; end
      if (pin_h2[0] && !pin_h3[0]) nf[0] = 1;
      if (pin_h2[1] && !pin_h3[1]) nf[1] = 1;
      if (rx_data_rd || rx_busy) nf[2] = 0;
      if (rx_done) nf[2] = 1;
      if (tx_load) nf[3] = 0;
      if (tx_done) nf[3] = 1;
      m_int = |(m_flag & m_mask);
      if (rd_en && sel == 4'b1010)      m_rdata = {pin_h2, m_mask};
      else if (rd_en && sel == 4'b1011) m_rdata = {4'h0, m_flag};
      else                              m_rdata = 0;
      if (wr_en && sel == 4'b1010) m_mask = wdata[3:0];
      m_flag = nf;
      pin_h3 = pin_h2; pin_h2 = pin_h1;
      pin_h1 = {cl_stat, sd_stat, pb_pin, irq_pin};
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // advance one cycle: compare model at the falling edge, then drive
  task automatic step();
    @(negedge clk);
    cyc++;
    if (!rst) begin
      chk(rd_tag, rdata, m_rdata);
      chk("R9", {7'b0, int_req}, {7'b0, m_int});
    end
    rd_tag = !rd_en ? "R10" : (sel == 4'b1010) ? "R2 R3" :
             (sel == 4'b1011) ? "R5 R4 R6 R7 R8" : "R10";
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; rx_done = 0; rx_busy = 0; rx_data_rd = 0;
    tx_done = 0; tx_load = 0;
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1: reset state
    chk("R1", rdata, 8'h00); chk("R1", {7'b0, int_req}, 8'h00);
    sel = 4'b1011; rd_en = 1; step(); rd_en = 0;
    chk("R1", rdata, 8'h00);
    // R2: mask write/read
    sel = 4'b1010; wr_en = 1; wdata = 8'hF5; step(); wr_en = 0; rd_en = 1; step(); rd_en = 0;
    chk("R2", rdata, 8'h05);
    // R4: irq pin rise sets flag bit 0
    irq_pin = 1; repeat (4) step();
    sel = 4'b1011; rd_en = 1; step(); rd_en = 0;
    chk("R4", rdata, 8'h01);
    // R3: synced levels of irq pin in mask read
    sel = 4'b1010; rd_en = 1; step(); rd_en = 0;
    chk("R3", rdata, 8'h15);
    // R5: write clears bits 0/1 only
    sel = 4'b1011; wr_en = 1; wdata = 8'h0C; step(); wr_en = 0;
    // R8: set wins against strobes and busy
    rx_done = 1; rx_data_rd = 1; rx_busy = 1; tx_done = 1; tx_load = 1; step(); idle();
    rd_en = 1; step(); rd_en = 0;
    chk("R8", rdata, 8'h0C);
    // R10: reading flags does not clear them
    rd_en = 1; step(); rd_en = 0;
    chk("R10", rdata, 8'h0C);
    // R6 R7: clears by strobes
    rx_busy = 1; tx_load = 1; step(); idle(); rd_en = 1; step(); rd_en = 0;
    chk("R6 R7", rdata, 8'h00);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      sel     = ($urandom_range(0, 3) != 0) ? {3'b101, 1'($urandom)} : 4'($urandom);
      rd_en   = 1'($urandom);
      wr_en   = ($urandom_range(0, 5) == 0);
      wdata   = 8'($urandom);
      irq_pin = ($urandom_range(0, 3) == 0) ? ~irq_pin : irq_pin;
      pb_pin  = ($urandom_range(0, 3) == 0) ? ~pb_pin : pb_pin;
      cl_stat = 1'($urandom); sd_stat = 1'($urandom);
      rx_done = ($urandom_range(0, 6) == 0); rx_busy = ($urandom_range(0, 4) == 0);
      rx_data_rd = ($urandom_range(0, 6) == 0);
      tx_done = ($urandom_range(0, 6) == 0); tx_load = ($urandom_range(0, 6) == 0);
      step();
    end
    idle(); step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule